// File: doc/BRIEF.md
# Multi-format asynchronous serial receiver with error flags

This block receives characters on an asynchronous serial line. A baud-rate generator outside the block supplies an enable, `tick16`, that pulses once for each of the 16 sub-intervals of a bit period. The line first passes through a two-stage synchronizer. The block then qualifies the start bit and samples every data bit and the parity bit at the middle of the bit. It judges the stop bit by a two-out-of-three vote.

The receiver handles five frame layouts, selected by `fmt_sel`: nine data bits, eight data bits plus parity, eight data bits, seven data bits plus parity, and seven data bits. Each completed character is copied into a receive buffer, and `rx_irq` pulses for one clock to announce it. The moment of that copy depends on the layout. The nine-bit and eight-plus-parity layouts report at the middle of the ninth bit, before the stop bit arrives. The other layouts report once the stop bit has been judged.

Parity, framing and overrun problems are reported on three sticky flags. A host uses `buf_read` to mark that it has taken the buffer, and `err_clr` to clear the flags.

Top module: `mf_uart_rx`

## Requirements
- R1: While `rst_n` is low, `rx_data`, `rx_bit8`, `rx_irq`, `perr`, `ferr` and `oerr` are all 0.
- R2: A low level seen on the synchronized line while idle begins a start bit, and that tick counts as sub-tick 0. The character is dropped if the line is high again at sub-tick 8. A dropped start bit gives no `rx_irq` and leaves `rx_data` unchanged.
- R3: Bits arrive least significant first. Each bit is sampled at sub-tick 8 of its period. The `fmt_sel` codes are: 0 = nine data bits, 1 = eight data bits plus parity, 2 = eight data bits, 3 = seven data bits plus parity, 4 = seven data bits (codes 5 to 7 behave as 2). The first eight data bits go to `rx_data[7:0]`. In the seven-bit codes, `rx_data[7]` is 0, including when a parity bit follows. The ninth data bit goes to `rx_bit8` in code 0, and `rx_bit8` is loaded with 0 in every other code.
- R4: `rx_irq` is high for exactly one clock, and `rx_data` holds the new character in that clock. It rises one clock after the tick of the event. In codes 0 and 1 the event is sub-tick 8 of the ninth bit. In codes 2, 3 and 4 it is sub-tick 9 of the stop bit.
- R5: The stop bit is sampled at sub-ticks 7, 8 and 9. When at least two of the three samples are 0, `ferr` rises one clock after sub-tick 9, in every code. In code 0 this is 17 ticks after the event that raised `rx_irq`.
- R6: `odd_par` = 0 selects even parity and 1 selects odd parity. Parity is wrong when the parity bit, added to the count of ones in the data bits, does not give the selected sense. A wrong parity raises `perr` in the same clock as `rx_irq`: in code 1 at the parity bit, in code 3 at the stop bit. Codes 0, 2 and 4 never raise `perr`.
- R7: `perr`, `ferr` and `oerr` stay high until a clock with `err_clr` high clears them.
- R8: A character that is loaded while the previous one has not been read raises `oerr` in the same clock as `rx_irq`. The previous character has been read if `buf_read` was high at some point since its load, including in the load clock. The new character still replaces the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit period |
| rxd | input | 1 | Serial line, idle high |
| fmt_sel | input | 3 | Frame layout code |
| odd_par | input | 1 | 0 even parity, 1 odd parity |
| buf_read | input | 1 | Host has taken the receive buffer |
| err_clr | input | 1 | Clears the three error flags |
| rx_data | output | 8 | Receive buffer, first eight data bits |
| rx_bit8 | output | 1 | Ninth data bit (code 0 only) |
| rx_irq | output | 1 | One-clock character-ready pulse |
| perr | output | 1 | Sticky parity error |
| ferr | output | 1 | Sticky framing error |
| oerr | output | 1 | Sticky overrun error |

## Verification
Frames are sent in every layout code. The data patterns are chosen so that the top buffer bit and the ninth bit would expose a misaligned or unmasked field. For example, seven ones followed by a set parity bit separates a zero-filled buffer from a leaked parity bit.

Stop bits are shaped at sub-tick resolution: one low sample, two low samples, and a wide low pulse. These separate a true majority vote from single-sample or unanimous judging. Measuring the gap between `rx_irq` and `ferr` in the nine-bit code separates the early report from the stop-bit report.

A start pulse that ends exactly at the qualifying sample, and a pair of unread characters with and without an intervening read, cover the rejection and overrun paths. Even and odd parity are each tried with correct and wrong parity bits.

// File: rtl/mfrx_pkg.sv
package mfrx_pkg;
  localparam int FRAME_MAX = 9;

  typedef enum logic [2:0] {
    FMT_D9  = 3'd0,
    FMT_D8P = 3'd1,
    FMT_D8  = 3'd2,
    FMT_D7P = 3'd3,
    FMT_D7  = 3'd4
  } rx_fmt_e;

  // bits between start and stop, parity included
  function automatic logic [3:0] payload_len(input logic [2:0] f);
    case (f)
      FMT_D9, FMT_D8P: return 4'd9;
      FMT_D7P:         return 4'd8;
      FMT_D7:          return 4'd7;
      default:         return 4'd8;
    endcase
  endfunction

  function automatic logic early_report(input logic [2:0] f);
    return (f == FMT_D9) || (f == FMT_D8P);
  endfunction

  function automatic logic parity_at_ninth(input logic [2:0] f);
    return f == FMT_D8P;
  endfunction

  function automatic logic parity_at_stop(input logic [2:0] f);
    return f == FMT_D7P;
  endfunction

  // true when two or more of the three stop samples are low
  function automatic logic vote_low(input logic a, input logic b, input logic c);
    return (!a && !b) || (!a && !c) || (!b && !c);
  endfunction

  function automatic logic parity_wrong(input logic [FRAME_MAX-1:0] fr,
                                        input logic [2:0] f, input logic odd);
    if (f == FMT_D8P) return (^fr[8:0]) != odd;
    if (f == FMT_D7P) return (^fr[7:0]) != odd;
    return 1'b0;
  endfunction

  function automatic logic [7:0] pick_data(input logic [FRAME_MAX-1:0] fr,
                                           input logic [2:0] f);
    if (f == FMT_D7P || f == FMT_D7) return {1'b0, fr[6:0]};
    return fr[7:0];
  endfunction

  function automatic logic pick_bit8(input logic [FRAME_MAX-1:0] fr,
                                     input logic [2:0] f);
    return (f == FMT_D9) ? fr[8] : 1'b0;
  endfunction
endpackage

// File: rtl/mfrx_sync.sv
module mfrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '1;
    else        q <= {q[STAGES-2:0], din};
  end

  assign dout = q[STAGES-1];
endmodule

// File: rtl/mfrx_frame_ctrl.sv
module mfrx_frame_ctrl
  import mfrx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 line,
  input  logic [2:0]           fmt,
  output logic                 ev_last,
  output logic                 ev_stop,
  output logic                 stop_low,
  output logic [FRAME_MAX-1:0] frame_now
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(FRAME_MAX + 2);
  localparam logic [CW-1:0] MID_C  = CW'(OSR / 2);
  localparam logic [CW-1:0] V_LO   = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] V_HI   = CW'(OSR / 2 + 1);
  localparam logic [CW-1:0] LAST_C = CW'(OSR - 1);

  logic                 active;
  logic [CW-1:0]        cnt;
  logic [BW-1:0]        bitn;
  logic [FRAME_MAX-1:0] shreg;
  logic                 v_lo, v_mid;
  logic [BW-1:0]        plen, stop_idx;
  logic                 at_mid, ev_abort, ev_data;

  assign plen     = BW'(payload_len(fmt));
  assign stop_idx = plen + BW'(1);
  assign at_mid   = tick && active && (cnt == MID_C);
  assign ev_abort = at_mid && (bitn == '0) && line;
  assign ev_data  = at_mid && (bitn != '0) && (bitn <= plen);
  assign ev_last  = ev_data && (bitn == plen);
  assign ev_stop  = tick && active && (bitn == stop_idx) && (cnt == V_HI);
  assign stop_low = vote_low(v_lo, v_mid, line);

  always_comb begin
    frame_now = shreg;
    for (int i = 0; i < FRAME_MAX; i++)
      if (ev_data && (bitn == BW'(i + 1))) frame_now[i] = line;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      bitn   <= '0;
      shreg  <= '0;
      v_lo   <= 1'b1;
      v_mid  <= 1'b1;
    end else if (tick) begin
      if (!active) begin
        if (!line) begin
          active <= 1'b1;
          cnt    <= CW'(1);
          bitn   <= '0;
          shreg  <= '0;
        end
      end else if (ev_abort || ev_stop) begin
        active <= 1'b0;
      end else begin
        shreg <= frame_now;
        if (bitn == stop_idx && cnt == V_LO)  v_lo  <= line;
        if (bitn == stop_idx && cnt == MID_C) v_mid <= line;
        if (cnt == LAST_C) begin
          cnt  <= '0;
          bitn <= bitn + BW'(1);
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/mfrx_report.sv
module mfrx_report
  import mfrx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           fmt,
  input  logic                 odd_par,
  input  logic                 buf_read,
  input  logic                 err_clr,
  input  logic                 ev_last,
  input  logic                 ev_stop,
  input  logic                 stop_low,
  input  logic [FRAME_MAX-1:0] frame_now,
  output logic [7:0]           rx_data,
  output logic                 rx_bit8,
  output logic                 rx_irq,
  output logic                 perr,
  output logic                 ferr,
  output logic                 oerr
);
  logic load_evt, par_evt, set_pe, set_fe, set_oe, full;

  assign load_evt = early_report(fmt) ? ev_last : ev_stop;
  assign par_evt  = (parity_at_ninth(fmt) && ev_last) ||
                    (parity_at_stop(fmt) && ev_stop);
  assign set_pe   = par_evt && parity_wrong(frame_now, fmt, odd_par);
  assign set_fe   = ev_stop && stop_low;
  assign set_oe   = load_evt && full && !buf_read;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data <= '0;
      rx_bit8 <= 1'b0;
      rx_irq  <= 1'b0;
      full    <= 1'b0;
      perr    <= 1'b0;
      ferr    <= 1'b0;
      oerr    <= 1'b0;
    end else begin
      rx_irq <= load_evt;
      if (load_evt) begin
        rx_data <= pick_data(frame_now, fmt);
        rx_bit8 <= pick_bit8(frame_now, fmt);
        full    <= 1'b1;
      end else if (buf_read) begin
        full <= 1'b0;
      end
      perr <= set_pe || (perr && !err_clr);
      ferr <= set_fe || (ferr && !err_clr);
      oerr <= set_oe || (oerr && !err_clr);
    end
  end
endmodule

// File: rtl/mf_uart_rx.sv
module mf_uart_rx
  import mfrx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic [2:0] fmt_sel,
  input  logic       odd_par,
  input  logic       buf_read,
  input  logic       err_clr,
  output logic [7:0] rx_data,
  output logic       rx_bit8,
  output logic       rx_irq,
  output logic       perr,
  output logic       ferr,
  output logic       oerr
);
  logic                 rxd_s;
  logic                 ev_last, ev_stop, stop_low;
  logic [FRAME_MAX-1:0] frame_now;

  mfrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxd_s)
  );

  mfrx_frame_ctrl #(.OSR(OSR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .line(rxd_s), .fmt(fmt_sel),
    .ev_last(ev_last), .ev_stop(ev_stop), .stop_low(stop_low),
    .frame_now(frame_now)
  );

  mfrx_report u_rep (
    .clk(clk), .rst_n(rst_n), .fmt(fmt_sel), .odd_par(odd_par),
    .buf_read(buf_read), .err_clr(err_clr), .ev_last(ev_last),
    .ev_stop(ev_stop), .stop_low(stop_low), .frame_now(frame_now),
    .rx_data(rx_data), .rx_bit8(rx_bit8), .rx_irq(rx_irq),
    .perr(perr), .ferr(ferr), .oerr(oerr)
  );
endmodule

// File: rtl/mf_uart_rx_chk.sv
module mf_uart_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] fmt_sel,
  input logic       err_clr,
  input logic       rx_irq,
  input logic       rx_bit8,
  input logic       perr,
  input logic       ferr,
  input logic       oerr,
  input logic       ev_stop
);
  // R4
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);

  // R4
  late_irq_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq && $stable(fmt_sel) && (fmt_sel == 3'd2 || fmt_sel == 3'd3 || fmt_sel == 3'd4))
      |-> $past(ev_stop));

  // R5
  ferr_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ferr) |-> $past(ev_stop));

  // R6
  perr_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perr) |-> ($past(fmt_sel) == 3'd1 || $past(fmt_sel) == 3'd3));

  // R7
  perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (perr && !err_clr) |=> perr);

  // R7
  ferr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ferr && !err_clr) |=> ferr);

  // R7
  oerr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oerr && !err_clr) |=> oerr);

  // R8
  oerr_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oerr) |-> rx_irq);

  // R3
  bit8_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq && fmt_sel != 3'd0) |-> !rx_bit8);
endmodule

bind mf_uart_rx mf_uart_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .err_clr(err_clr),
  .rx_irq(rx_irq), .rx_bit8(rx_bit8), .perr(perr), .ferr(ferr),
  .oerr(oerr), .ev_stop(ev_stop)
);

// File: tb/mf_uart_rx_bench.sv
`timescale 1ns/1ps
module mf_uart_rx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16 = 1'b0;
  logic rxd = 1'b1;
  logic [2:0] fmt_sel = 3'd2;
  logic odd_par = 1'b0, buf_read = 1'b0, err_clr = 1'b0;
  logic [7:0] rx_data;
  logic rx_bit8, rx_irq, perr, ferr, oerr;

  always #10 clk = ~clk;

  mf_uart_rx u_mf_uart_rx (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .fmt_sel(fmt_sel),
    .odd_par(odd_par), .buf_read(buf_read), .err_clr(err_clr),
    .rx_data(rx_data), .rx_bit8(rx_bit8), .rx_irq(rx_irq),
    .perr(perr), .ferr(ferr), .oerr(oerr)
  );

  localparam int TDIV = 3;
  int tdiv = 0;
  always @(posedge clk) begin
    if (tdiv == TDIV - 1) begin tdiv <= 0; tick16 <= 1'b1; end
    else begin tdiv <= tdiv + 1; tick16 <= 1'b0; end
  end

  int n_chk = 0, n_bad = 0;
  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: position counter in ticks since start edge
  int pos, mbits[9], cyc;
  logic m_s1, m_s2, mv7, mv8, m_full;
  logic e_irq, e_b8, e_pe, e_fe, e_oe;
  logic [7:0] e_data;

  always @(posedge clk) begin
    int b, w, n, ones, dn;
    logic line, load, pset, fset, early;
    cyc++;
    if (!rst_n) begin
      pos = -1; m_s1 = 1; m_s2 = 1; mv7 = 1; mv8 = 1; m_full = 0;
      e_irq = 0; e_b8 = 0; e_pe = 0; e_fe = 0; e_oe = 0; e_data = 0;
      for (int i = 0; i < 9; i++) mbits[i] = 0;
    end else begin
      line = m_s2; load = 0; pset = 0; fset = 0;
      n = (fmt_sel <= 1) ? 9 : (fmt_sel == 4) ? 7 : 8;
      early = (fmt_sel <= 1);
      if (tick16) begin
        if (pos < 0) begin
          if (!line) begin pos = 0; for (int i = 0; i < 9; i++) mbits[i] = 0; end
        end else begin
          pos++; b = pos / 16; w = pos % 16;
          if (b == 0) begin
            if (w == 8 && line) pos = -1;
          end else if (b <= n) begin
            if (w == 8) begin
              mbits[b-1] = int'(line);
              if (b == n) begin
                if (early) load = 1;
                if (fmt_sel == 1) begin
                  ones = 0; for (int i = 0; i < n; i++) ones += mbits[i];
                  pset = ((ones % 2) != int'(odd_par));
                end
              end
            end
          end else begin
            if (w == 7) mv7 = line;
            else if (w == 8) mv8 = line;
            else if (w == 9) begin
              fset = (int'(mv7) + int'(mv8) + int'(line)) < 2;
              if (!early) load = 1;
              if (fmt_sel == 3) begin
                ones = 0; for (int i = 0; i < n; i++) ones += mbits[i];
                pset = ((ones % 2) != int'(odd_par));
              end
              pos = -1;
            end
          end
        end
      end
      e_irq = load;
      if (err_clr) begin e_pe = 0; e_fe = 0; e_oe = 0; end
      if (pset) e_pe = 1;
      if (fset) e_fe = 1;
      if (load) begin
        if (m_full && !buf_read) e_oe = 1;
        m_full = 1;
        dn = (fmt_sel == 3 || fmt_sel == 4) ? 7 : 8;
        for (int i = 0; i < 8; i++) e_data[i] = (i < dn) ? mbits[i][0] : 1'b0;
        e_b8 = (fmt_sel == 0) ? mbits[8][0] : 1'b0;
      end else if (buf_read) m_full = 0;
      m_s2 = m_s1; m_s1 = rxd;
    end
  end

  // per-clock comparison and event capture
  int irq_cnt = 0, irq_cyc = 0, ferr_cyc = 0, perr_cyc = 0;
  logic [7:0] cap_data = 0;
  logic cap_b8 = 0, p_ferr = 0, p_perr = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 irq", {8'd0, rx_irq}, {8'd0, e_irq});
      chk("R3 data", {1'b0, rx_data}, {1'b0, e_data});
      chk("R3 bit8", {8'd0, rx_bit8}, {8'd0, e_b8});
      chk("R6 perr", {8'd0, perr}, {8'd0, e_pe});
      chk("R5 ferr", {8'd0, ferr}, {8'd0, e_fe});
      chk("R8 oerr", {8'd0, oerr}, {8'd0, e_oe});
      if (rx_irq) begin irq_cnt++; irq_cyc = cyc; cap_data = rx_data; cap_b8 = rx_bit8; end
      if (ferr && !p_ferr) ferr_cyc = cyc;
      if (perr && !p_perr) perr_cyc = cyc;
      p_ferr = ferr; p_perr = perr;
    end
  end

  task automatic put(input logic v);
    rxd = v;
    do @(negedge clk); while (tick16 !== 1'b1);
  endtask

  task automatic send(input int nb, input logic [9:0] bits, input logic [15:0] stp);
    for (int t = 0; t < 16; t++) put(1'b0);
    for (int k = 0; k < nb; k++) for (int t = 0; t < 16; t++) put(bits[k]);
    for (int t = 0; t < 16; t++) put(stp[t]);
    for (int t = 0; t < 6; t++) put(1'b1);
  endtask

  task automatic pulse_read;
    buf_read = 1'b1; @(negedge clk); buf_read = 1'b0;
  endtask

  task automatic pulse_clr;
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
  endtask

  function automatic logic pbit(input logic [7:0] d, input int nd, input logic odd);
    logic x = odd;
    for (int i = 0; i < nd; i++) x ^= d[i];
    return x;
  endfunction

  initial begin
    int k0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs", {rx_data, rx_irq}, 9'd0);
    chk("R1 reset flags", {6'd0, perr, ferr, oerr}, 9'd0);
    chk("R1 reset bit8", {8'd0, rx_bit8}, 9'd0);
    rst_n = 1'b1;
    for (int t = 0; t < 4; t++) put(1'b1);

    // R3 R4 eight-bit character
    fmt_sel = 3'd2; k0 = irq_cnt;
    send(8, {2'b0, 8'hA5}, 16'hFFFF);
    chk("R4 one irq", 9'(irq_cnt - k0), 9'd1);
    chk("R3 data 8bit", {1'b0, cap_data}, 9'h0A5);
    chk("R5 no ferr good stop", {8'd0, ferr}, 9'd0);
    pulse_read;

    // R2 start low only up to sub-tick 7
    k0 = irq_cnt;
    for (int t = 0; t < 8; t++) put(1'b0);
    for (int t = 0; t < 24; t++) put(1'b1);
    chk("R2 no irq on rejected start", 9'(irq_cnt - k0), 9'd0);
    chk("R2 buffer untouched", {1'b0, rx_data}, 9'h0A5);

    // R3 seven-bit character
    fmt_sel = 3'd4;
    send(7, {3'b0, 7'h2B}, 16'hFFFF);
    chk("R3 data 7bit", {1'b0, cap_data}, 9'h02B);
    pulse_read;

    // R3 R4 R5 nine-bit with bad stop
    fmt_sel = 3'd0;
    send(9, 10'h1C3, 16'hFC3F);
    chk("R3 nine-bit low byte", {1'b0, cap_data}, 9'h0C3);
    chk("R3 nine-bit bit8", {8'd0, cap_b8}, 9'd1);
    chk("R5 ferr on low stop", {8'd0, ferr}, 9'd1);
    chk("R4 R5 ferr 17 ticks after irq", 9'(ferr_cyc - irq_cyc), 9'(17 * TDIV));
    chk("R6 no perr in nine-bit", {8'd0, perr}, 9'd0);
    pulse_read; pulse_clr;

    // R6 eight plus parity, even, wrong parity bit
    fmt_sel = 3'd1; odd_par = 1'b0;
    send(9, {1'b0, ~pbit(8'h3C, 8, 1'b0), 8'h3C}, 16'hFFFF);
    chk("R6 perr even wrong", {8'd0, perr}, 9'd1);
    chk("R6 perr with irq at parity bit", 9'(perr_cyc - irq_cyc), 9'd0);
    chk("R3 data 8P", {1'b0, cap_data}, 9'h03C);
    pulse_read; pulse_clr;

    // R6 odd parity correct
    odd_par = 1'b1;
    send(9, {1'b0, pbit(8'h01, 8, 1'b1), 8'h01}, 16'hFFFF);
    chk("R6 odd correct no perr", {8'd0, perr}, 9'd0);
    pulse_read;

    // R3 zero-fill in seven plus parity with parity bit 1
    fmt_sel = 3'd3; odd_par = 1'b0;
    send(8, {2'b0, pbit(8'h7F, 7, 1'b0), 7'h7F}, 16'hFFFF);
    chk("R3 zero fill 7P", {1'b0, cap_data}, 9'h07F);
    chk("R6 7P correct", {8'd0, perr}, 9'd0);
    pulse_read;
    send(8, {2'b0, ~pbit(8'h55, 7, 1'b0), 7'h55}, 16'hFFFF);
    chk("R6 7P wrong at stop", {8'd0, perr}, 9'd1);
    chk("R6 7P perr with irq", 9'(perr_cyc - irq_cyc), 9'd0);
    pulse_read; pulse_clr;

    // R5 majority vote
    fmt_sel = 3'd4;
    send(7, {3'b0, 7'h19}, 16'hFEFF);
    chk("R5 one low sample no ferr", {8'd0, ferr}, 9'd0);
    pulse_read;
    send(7, {3'b0, 7'h19}, 16'hFCFF);
    chk("R5 two low samples ferr", {8'd0, ferr}, 9'd1);
    chk("R5 ferr with irq at stop", 9'(ferr_cyc - irq_cyc), 9'd0);
    pulse_read;
    // R7 sticky across a clean frame, then cleared
    send(7, {3'b0, 7'h06}, 16'hFFFF);
    chk("R7 ferr held", {8'd0, ferr}, 9'd1);
    pulse_read; pulse_clr;
    chk("R7 ferr cleared", {8'd0, ferr}, 9'd0);

    // R8 overrun
    fmt_sel = 3'd2;
    send(8, {2'b0, 8'h11}, 16'hFFFF);
    send(8, {2'b0, 8'h22}, 16'hFFFF);
    chk("R8 oerr on unread", {8'd0, oerr}, 9'd1);
    chk("R8 new char replaces", {1'b0, cap_data}, 9'h022);
    pulse_read; pulse_clr;
    send(8, {2'b0, 8'h33}, 16'hFFFF);
    chk("R8 no oerr after read", {8'd0, oerr}, 9'd0);
    pulse_read;

    // R6 nine-bit never flags parity
    fmt_sel = 3'd0; odd_par = 1'b1;
    send(9, 10'h0AA, 16'hFFFF);
    chk("R6 nine-bit odd sense no perr", {8'd0, perr}, 9'd0);
    chk("R3 nine-bit bit8 zero", {8'd0, cap_b8}, 9'd0);

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R4 watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule